// File: doc/BRIEF.md
# Reset and Power Mode Controller

This block decides, cycle by cycle, whether the core of a small 8-bit microcontroller runs, sits in idle, or is powered down, and when a reset on the external reset pin is genuine. It produces a core clock gate, an oscillator run enable, a core reset, a one-cycle strobe that reloads the special function registers, and a two-bit mode code that the pin drivers use to park the address-latch and program-strobe outputs.

Software asks for idle or power-down through two request inputs. Idle keeps the oscillator running and gates only the core clock; any enabled interrupt brings the core back. Power-down stops the oscillator. It ends either through the reset pin or through an external interrupt pin that is enabled and set to level mode. The interrupt exit has two phases. A low level restarts the oscillator, and a programmable settling count then runs. The core clock returns only once that count has run out and the pin has gone back high. An interrupt exit keeps all register contents, so no reload strobe is issued.

The controller runs on the oscillator-domain clock. It treats the oscillator as usable only while its run enable is on and, after a restart, only once the settling count has run out.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A reset is accepted only after `resetPin` has been sampled high on CYC_PER_MC*RST_MC (24 by default) consecutive clock edges with the oscillator stable. `coreRst` rises after the 24th such edge. A pulse of 23 edges has no effect.
- R2: On acceptance, `sfrRstStb` is high for exactly one cycle. `coreRst` stays high while `resetPin` stays high, and the cycle after `resetPin` is sampled low the controller is back in run mode.
- R3: In run mode, `pdReq` enters power-down on the next edge: `oscRun`=0, `coreClkEn`=0, `pinMode`=2'b10 (pin drivers hold the address-latch and program strobes at 0). `pdReq` wins over a simultaneous `idleReq`.
- R4: In run mode, `idleReq` without `pdReq` enters idle: `coreClkEn`=0, `oscRun`=1, `pinMode`=2'b01 (strobes held at 1), and no `sfrRstStb`.
- R5: Idle is left one edge after `anyIntPend` is sampled high (`pinMode`=2'b00, `coreClkEn`=1), or through an accepted reset.
- R6: In power-down, an external pin i wakes the oscillator only while `intPinN[i]`=0, `intEn[i]`=1 and `intLevel[i]`=1, where 1 means level mode. A disabled pin or a pin in edge mode (`intLevel[i]`=0) that is held low leaves `oscRun` at 0.
- R7: After a qualifying low level, `oscRun` is 1 one edge later, `pinMode` stays 2'b10, and `coreClkEn` stays 0 while the pin is held low. Once the pin is back high and settling is done, run mode resumes with no `sfrRstStb`.
- R8: With `stabLimit`=S, `coreClkEn` returns no earlier than S+1 edges after the edge that set `oscRun`. If the wake pin is already high, it returns exactly then. The core clock is never enabled on the edge that follows a cycle with `oscRun`=0.
- R9: `resetPin` high in power-down restarts the oscillator. Once settling is done, the R1 qualification runs. If the pin drops before acceptance, the controller returns to power-down with `oscRun`=0 and no reset.
- R10: An accepted reset overrides any pending exit, whether from idle or from an interrupt wake, and leads through R2 back to run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| resetPin | input | 1 | External reset pin, active high, unqualified |
| intPinN | input | 2 | External interrupt pins, active low |
| intEn | input | 2 | Per-pin interrupt enable |
| intLevel | input | 2 | Per-pin trigger mode, 1 = level, 0 = edge |
| anyIntPend | input | 1 | Some enabled interrupt is pending |
| idleReq | input | 1 | Software request for idle |
| pdReq | input | 1 | Software request for power-down |
| stabLimit | input | STAB_W | Oscillator settling count in clock edges |
| coreClkEn | output | 1 | Core clock gate enable |
| oscRun | output | 1 | Oscillator run enable |
| coreRst | output | 1 | Core reset, held during an accepted reset |
| sfrRstStb | output | 1 | One-cycle special function register reload strobe |
| pinMode | output | 2 | 00 run, 01 idle, 10 power-down |

## Verification
The embedded properties check several rules on every cycle. The reload strobe lasts one cycle and only appears together with the core reset. The core reset holds while the pin stays high. The core clock never ungates straight out of a stopped-oscillator cycle. The qualification and settling counters stay inside their bounds. Power-down wins over idle, and idle leaves on a pending interrupt. The bench scenarios are needed for behaviour that spans many cycles or depends on a filter: the exact 23-versus-24 edge boundary of reset acceptance, the S+1 edge settling latency, the requirement that a wake pin be both enabled and in level mode, the two-phase low-then-high exit, and the return to power-down after a reset pin glitch.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [2:0] {
    S_RUN      = 3'd0,
    S_IDLE     = 3'd1,
    S_PD       = 3'd2,
    S_WAKE_INT = 3'd3,
    S_WAKE_RST = 3'd4,
    S_RST_HOLD = 3'd5
  } pwrState_e;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_IDLE = 2'b01;
  localparam logic [1:0] MODE_PD   = 2'b10;

  // strobes from control to counters
  typedef struct packed {
    logic stabClr;  // restart settling count
    logic stabRun;  // settling count advances
    logic qualRun;  // oscillator stable, reset qualification may count
  } ctrlStb_t;

endpackage

// File: rtl/pwr_counters.sv
module pwr_counters
  import pwr_pkg::*;
#(
  parameter int CYC_PER_MC = 12,
  parameter int RST_MC     = 2,
  parameter int STAB_W     = 16,
  parameter int N_EXT      = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  ctrlStb_t          stb,
  input  logic              resetPin,
  input  logic [N_EXT-1:0]  intPinN,
  input  logic [N_EXT-1:0]  intEn,
  input  logic [N_EXT-1:0]  intLevel,
  input  logic [STAB_W-1:0] stabLimit,
  output logic              qualHit,
  output logic              stabDone,
  output logic              wakeLow
);

  localparam int QUAL_LEN = CYC_PER_MC * RST_MC;
  localparam int QW       = $clog2(QUAL_LEN + 1);

  logic [QW-1:0]     qualCnt;
  logic [STAB_W-1:0] stabCnt;
  logic [N_EXT-1:0]  pinWake;

  // reset pin qualification: consecutive stable-clock edges with pin high
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      qualCnt <= '0;
    end else if (!resetPin || !stb.qualRun || qualHit) begin
      qualCnt <= '0;
    end else begin
      qualCnt <= qualCnt + 1'b1;
    end
  end

  assign qualHit = stb.qualRun && resetPin && (qualCnt == QW'(QUAL_LEN - 1));

  // oscillator settling counter
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stabCnt <= '0;
    end else if (stb.stabClr) begin
      stabCnt <= '0;
    end else if (stb.stabRun && (stabCnt < stabLimit)) begin
      stabCnt <= stabCnt + 1'b1;
    end
  end

  assign stabDone = stb.stabRun && (stabCnt >= stabLimit);

  // only enabled, level-configured pins held low may wake
  for (genvar i = 0; i < N_EXT; i++) begin : g_wake
    assign pinWake[i] = intEn[i] && intLevel[i] && !intPinN[i];
  end
  assign wakeLow = |pinWake;

  AST_QUAL_BOUND: assert property (@(posedge clk) disable iff (!porN)
    qualCnt < QW'(QUAL_LEN)); // R1

  AST_QUAL_DROP: assert property (@(posedge clk) disable iff (!porN)
    !resetPin |=> qualCnt == '0); // R1

  AST_STAB_HELD_IN_PD: assert property (@(posedge clk) disable iff (!porN)
    stb.stabClr |=> stabCnt == '0); // R8

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       resetPin,
  input  logic       anyIntPend,
  input  logic       idleReq,
  input  logic       pdReq,
  input  logic       qualHit,
  input  logic       stabDone,
  input  logic       wakeLow,
  output ctrlStb_t   stb,
  output logic       coreClkEn,
  output logic       oscRun,
  output logic       coreRst,
  output logic       sfrRstStb,
  output logic [1:0] pinMode
);

  pwrState_e state, stateNxt;
  logic      inWake;
  logic      oscStable;

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_RUN: begin
        if (qualHit)      stateNxt = S_RST_HOLD;
        else if (pdReq)   stateNxt = S_PD;
        else if (idleReq) stateNxt = S_IDLE;
      end
      S_IDLE: begin
        if (qualHit)         stateNxt = S_RST_HOLD;
        else if (anyIntPend) stateNxt = S_RUN;
      end
      S_PD: begin
        if (resetPin)     stateNxt = S_WAKE_RST;
        else if (wakeLow) stateNxt = S_WAKE_INT;
      end
      S_WAKE_INT: begin
        if (qualHit)                   stateNxt = S_RST_HOLD;
        else if (stabDone && !wakeLow) stateNxt = S_RUN;
      end
      S_WAKE_RST: begin
        if (qualHit)                    stateNxt = S_RST_HOLD;
        else if (stabDone && !resetPin) stateNxt = S_PD;
      end
      S_RST_HOLD: begin
        if (!resetPin) stateNxt = S_RUN;
      end
      default: stateNxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state     <= S_RUN;
      sfrRstStb <= 1'b0;
    end else begin
      state     <= stateNxt;
      sfrRstStb <= (stateNxt == S_RST_HOLD) && (state != S_RST_HOLD);
    end
  end

  assign inWake    = (state == S_WAKE_INT) || (state == S_WAKE_RST);
  assign oscStable = (state == S_RUN) || (state == S_IDLE) ||
                     (state == S_RST_HOLD) || (inWake && stabDone);

  assign stb.stabClr = (state == S_PD);
  assign stb.stabRun = inWake;
  assign stb.qualRun = oscStable && (state != S_RST_HOLD);

  assign oscRun    = (state != S_PD);
  assign coreClkEn = (state == S_RUN) || (state == S_RST_HOLD);
  assign coreRst   = (state == S_RST_HOLD);

  always_comb begin
    unique case (state)
      S_IDLE:                       pinMode = MODE_IDLE;
      S_PD, S_WAKE_INT, S_WAKE_RST: pinMode = MODE_PD;
      default:                      pinMode = MODE_RUN;
    endcase
  end

  AST_SFR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!porN)
    sfrRstStb |=> !sfrRstStb); // R2

  AST_SFR_WITH_RST: assert property (@(posedge clk) disable iff (!porN)
    sfrRstStb |-> coreRst); // R2

  AST_RST_HELD: assert property (@(posedge clk) disable iff (!porN)
    (coreRst && resetPin) |=> coreRst); // R2

  AST_PD_PRIORITY: assert property (@(posedge clk) disable iff (!porN)
    (state == S_RUN && pdReq && !qualHit) |=> (pinMode == MODE_PD && !oscRun)); // R3

  AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!porN)
    (state == S_IDLE && anyIntPend && !qualHit) |=> (pinMode == MODE_RUN && coreClkEn)); // R5

  AST_NO_UNGATE_FROM_STOP: assert property (@(posedge clk) disable iff (!porN)
    !oscRun |=> !coreClkEn); // R8

  AST_PD_IGNORES_REQ: assert property (@(posedge clk) disable iff (!porN)
    (state == S_PD && !resetPin && !wakeLow) |=> !oscRun); // R6

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int CYC_PER_MC = 12,
  parameter int RST_MC     = 2,
  parameter int STAB_W     = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              resetPin,
  input  logic [1:0]        intPinN,
  input  logic [1:0]        intEn,
  input  logic [1:0]        intLevel,
  input  logic              anyIntPend,
  input  logic              idleReq,
  input  logic              pdReq,
  input  logic [STAB_W-1:0] stabLimit,
  output logic              coreClkEn,
  output logic              oscRun,
  output logic              coreRst,
  output logic              sfrRstStb,
  output logic [1:0]        pinMode
);

  ctrlStb_t stb;
  logic     qualHit;
  logic     stabDone;
  logic     wakeLow;

  pwr_counters #(
    .CYC_PER_MC(CYC_PER_MC),
    .RST_MC    (RST_MC),
    .STAB_W    (STAB_W),
    .N_EXT     (2)
  ) counters_i (
    .clk      (clk),
    .porN     (porN),
    .stb      (stb),
    .resetPin (resetPin),
    .intPinN  (intPinN),
    .intEn    (intEn),
    .intLevel (intLevel),
    .stabLimit(stabLimit),
    .qualHit  (qualHit),
    .stabDone (stabDone),
    .wakeLow  (wakeLow)
  );

  pwr_fsm fsm_i (
    .clk       (clk),
    .porN      (porN),
    .resetPin  (resetPin),
    .anyIntPend(anyIntPend),
    .idleReq   (idleReq),
    .pdReq     (pdReq),
    .qualHit   (qualHit),
    .stabDone  (stabDone),
    .wakeLow   (wakeLow),
    .stb       (stb),
    .coreClkEn (coreClkEn),
    .oscRun    (oscRun),
    .coreRst   (coreRst),
    .sfrRstStb (sfrRstStb),
    .pinMode   (pinMode)
  );

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;

  localparam int STAB = 5;
  localparam int QUAL = 24;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        resetPin = 1'b0;
  logic [1:0]  intPinN = 2'b11;
  logic [1:0]  intEn = 2'b00;
  logic [1:0]  intLevel = 2'b00;
  logic        anyIntPend = 1'b0;
  logic        idleReq = 1'b0;
  logic        pdReq = 1'b0;
  logic [15:0] stabLimit = 16'(STAB);
  logic        coreClkEn, oscRun, coreRst, sfrRstStb;
  logic [1:0]  pinMode;

  int checks = 0;
  int errors = 0;
  int sfrPulses = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk(clk), .porN(porN), .resetPin(resetPin), .intPinN(intPinN),
    .intEn(intEn), .intLevel(intLevel), .anyIntPend(anyIntPend),
    .idleReq(idleReq), .pdReq(pdReq), .stabLimit(stabLimit),
    .coreClkEn(coreClkEn), .oscRun(oscRun), .coreRst(coreRst),
    .sfrRstStb(sfrRstStb), .pinMode(pinMode)
  );

  always @(negedge clk) if (porN && sfrRstStb) sfrPulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enter_pd();
    pdReq = 1'b1; tick(); pdReq = 1'b0;
  endtask

  task automatic wake_to_run();
    intEn = 2'b01; intLevel = 2'b01; intPinN = 2'b10;
    tick();
    intPinN = 2'b11;
    tick(STAB + 2);
  endtask

  task automatic t_reset_state();
    chk("R3 reset coreClkEn", coreClkEn, 1);
    chk("R3 reset oscRun", oscRun, 1);
    chk("R2 reset coreRst", coreRst, 0);
    chk("R2 reset sfrRstStb", sfrRstStb, 0);
    chk("R3 reset pinMode", pinMode, 0);
  endtask

  task automatic t_short_pulse();
    resetPin = 1'b1; tick(QUAL - 1);
    chk("R1 23 edges no reset", coreRst, 0);
    resetPin = 1'b0; tick(2);
    chk("R1 short pulse ignored", coreRst, 0);
    chk("R1 short pulse no strobe", sfrPulses, 0);
  endtask

  task automatic t_full_reset();
    resetPin = 1'b1; tick(QUAL);
    chk("R1 24 edges reset", coreRst, 1);
    chk("R2 strobe high", sfrRstStb, 1);
    tick(3);
    chk("R2 strobe one cycle", sfrRstStb, 0);
    chk("R2 core reset held", coreRst, 1);
    resetPin = 1'b0; tick();
    chk("R2 back to run", coreRst, 0);
    chk("R2 run mode", pinMode, 0);
    chk("R2 one pulse", sfrPulses, 1);
  endtask

  task automatic t_idle();
    int p0 = sfrPulses;
    idleReq = 1'b1; tick(); idleReq = 1'b0;
    chk("R4 idle pinMode", pinMode, 1);
    chk("R4 idle clock gated", coreClkEn, 0);
    chk("R4 idle osc runs", oscRun, 1);
    tick(4);
    chk("R5 idle persists", pinMode, 1);
    anyIntPend = 1'b1; tick(); anyIntPend = 1'b0;
    chk("R5 idle exit pinMode", pinMode, 0);
    chk("R5 idle exit clock", coreClkEn, 1);
    chk("R4 idle no strobe", sfrPulses, p0);
  endtask

  task automatic t_priority();
    idleReq = 1'b1; pdReq = 1'b1; tick(); idleReq = 1'b0; pdReq = 1'b0;
    chk("R3 pd wins pinMode", pinMode, 2);
    chk("R3 pd osc off", oscRun, 0);
    chk("R3 pd clock gated", coreClkEn, 0);
  endtask

  task automatic t_wake_filter();
    // still in power-down from t_priority
    intEn = 2'b10; intLevel = 2'b01; intPinN = 2'b00; tick(3);
    chk("R6 edge/disabled pins ignored", oscRun, 0);
    intEn = 2'b11; intLevel = 2'b00; tick(2);
    chk("R6 edge-mode pins ignored", oscRun, 0);
    intPinN = 2'b11; intLevel = 2'b00; intEn = 2'b00;
  endtask

  task automatic t_two_phase();
    int p0 = sfrPulses;
    intEn = 2'b10; intLevel = 2'b10; intPinN = 2'b01; tick();
    chk("R7 osc restarted", oscRun, 1);
    chk("R7 still pd mode", pinMode, 2);
    tick(STAB + 5);
    chk("R7 gated while pin low", coreClkEn, 0);
    intPinN = 2'b11; tick();
    chk("R7 run after pin high", coreClkEn, 1);
    chk("R7 run mode", pinMode, 0);
    chk("R7 no strobe on int exit", sfrPulses, p0);
  endtask

  task automatic t_settle_latency();
    enter_pd();
    intEn = 2'b01; intLevel = 2'b01; intPinN = 2'b10; tick();
    intPinN = 2'b11;
    chk("R8 osc on", oscRun, 1);
    tick(STAB);
    chk("R8 gated at S edges", coreClkEn, 0);
    tick();
    chk("R8 ungated at S+1 edges", coreClkEn, 1);
  endtask

  task automatic t_pd_reset();
    enter_pd();
    resetPin = 1'b1; tick();
    chk("R9 osc restarted by reset pin", oscRun, 1);
    tick(STAB + QUAL - 1);
    chk("R9 not yet reset", coreRst, 0);
    tick();
    chk("R9 reset accepted", coreRst, 1);
    chk("R9 strobe", sfrRstStb, 1);
    resetPin = 1'b0; tick();
    chk("R9 run after reset", pinMode, 0);
  endtask

  task automatic t_pd_glitch();
    enter_pd();
    resetPin = 1'b1; tick(10);
    resetPin = 1'b0; tick();
    chk("R9 glitch back to pd osc", oscRun, 0);
    chk("R9 glitch pd mode", pinMode, 2);
    chk("R9 glitch no reset", coreRst, 0);
    wake_to_run();
    chk("R7 recovered run", coreClkEn, 1);
  endtask

  task automatic t_override();
    enter_pd();
    intEn = 2'b01; intLevel = 2'b01; intPinN = 2'b10; tick(STAB + 3);
    resetPin = 1'b1; tick(QUAL - 1);
    chk("R10 pending wake not yet reset", coreRst, 0);
    tick();
    chk("R10 reset overrides wake", coreRst, 1);
    resetPin = 1'b0; intPinN = 2'b11; tick();
    chk("R10 run after override", pinMode, 0);
    idleReq = 1'b1; tick(); idleReq = 1'b0;
    resetPin = 1'b1; tick(QUAL);
    chk("R10 reset exits idle", coreRst, 1);
    resetPin = 1'b0; tick();
    chk("R10 idle to run", coreClkEn, 1);
  endtask

  initial begin
    tick(2); porN = 1'b1; tick();
    t_reset_state();
    t_short_pulse();
    t_full_reset();
    t_idle();
    t_priority();
    t_wake_filter();
    t_two_phase();
    t_settle_latency();
    t_pd_reset();
    t_pd_glitch();
    t_override();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule